// File: doc/BRIEF.md
# Request-Triggered Block DMA Channel

This block is one DMA channel that copies data in blocks between two memory regions. Software programs the following and then raises an enable bit:

- a source address and a destination address;
- a per-request word count field (BC);
- a request count field (TC);
- a data-width code.

The channel then waits for a rising edge on a peripheral request line. Each edge causes BC+1 word copies. Each copy is a bus read from the source followed by a bus write to the destination. After a block the channel sits idle until the next edge. After TC+1 blocks it stops and raises a completion flag. The flag stays set until software clears it.

A peripheral such as a timer or an external interrupt source paces the transfers. Its interrupt output drives the request line, so each event moves one block. A request edge that arrives while a block is still running is held as pending, and the next block starts as soon as the current one ends. Dropping the enable bit stops the channel once the word in flight has been written.

Top module: `blkdma_channel`

## Requirements
- R1: A block starts only on a rising edge of `dreq`. A request line held high starts at most one block.
- R2: Each accepted request performs exactly BC+1 word copies. In each copy a read completes (`bus_rd` with `bus_rdy`) before the write of the same data is issued (`bus_wr`, `bus_wdata` equal to the read data).
- R3: After TC+1 accepted requests the channel has made (BC+1)×(TC+1) copies in total, and `busy` drops to 0.
- R4: Between blocks, and after start before the first request, the channel issues no bus access and `busy` stays 1.
- R5: A request edge that arrives during a block is held and starts the next block without any further edge. Edges and levels on `dreq` while the channel is not busy are ignored.
- R6: After every copy the source and destination addresses each advance by the stride. The stride comes from `cfg_width`: code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 4 bytes.
- R7: `done_irq` rises in the cycle after the final write completes. It stays 1, even while the enable bit is low, until `irq_clr` is pulsed or a new start occurs. If the flag is set and cleared in the same cycle, setting wins.
- R8: A start happens on a 0→1 change of `cfg_en` while the channel is idle. At that moment the channel samples all `cfg_*` inputs, and later changes to them have no effect on the running operation.
- R9: When `cfg_en` is cleared during an operation, the channel finishes the word in flight and then returns to idle with `busy` at 0 and `done_irq` at 0. It issues no further accesses.
- R10: After reset, `busy`, `done_irq`, `bus_rd` and `bus_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Enable; a 0→1 change starts the channel, and dropping it aborts |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_blk | input | CW | Words per request minus one (BC) |
| cfg_xfr | input | CW | Requests per operation minus one (TC) |
| cfg_width | input | 2 | Stride code: 0=1 byte, 1=2 bytes, 2 or 3=4 bytes |
| irq_clr | input | 1 | One-cycle pulse that clears the completion flag |
| dreq | input | 1 | Peripheral request line, acted on at its rising edges |
| bus_rd | output | 1 | Read strobe, held until `bus_rdy` |
| bus_wr | output | 1 | Write strobe, held until `bus_rdy` |
| bus_addr | output | AW | Byte address of the current access |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid when `bus_rdy` is 1 during a read |
| bus_rdy | input | 1 | Access complete |
| busy | output | 1 | The channel is running an operation |
| done_irq | output | 1 | Completion flag and interrupt |

## Verification
The two functions that can meet in one cycle are the capture of a new request edge and the consumption of an earlier request by the end of a block. They can also coincide with a running block that has not yet reached its last word. The bench provokes this by pulsing `dreq` right after the first write of a block has been seen, with bus latency stretched so that the block is still running. It then sends no further edges. The result counts as correct only if exactly two full blocks appear in the write log with the expected addresses and data, and `done_irq` is set.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } dma_state_e;

    // byte stride selected by the 2-bit width code
    function automatic logic [2:0] stride_of(input logic [1:0] code);
        case (code)
            2'd0:    stride_of = 3'd1;
            2'd1:    stride_of = 3'd2;
            default: stride_of = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/blkdma_req.sv
module blkdma_req (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic arm,
    input  logic take,
    output logic pend
);
    typedef struct packed {
        logic dreq;
        logic pend;
    } req_regs_t;

    req_regs_t r_d, r_q;
    logic      edge_seen;

    always_comb begin
        edge_seen = dreq & ~r_q.dreq;
        r_d.dreq  = dreq;
        // a new edge survives a same-cycle take of the older request
        r_d.pend  = arm & (edge_seen | (r_q.pend & ~take));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pend = r_q.pend;

    // R5: the block start only consumes a request that was captured
    a_r5_take_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> r_q.pend);

    // R1: a level that stays high creates no new pending request
    a_r1_level_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.dreq && dreq && !r_q.pend) |=> !r_q.pend);

endmodule

// File: rtl/blkdma_cnt.sv
module blkdma_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cfg_blk,
    input  logic [CW-1:0] cfg_xfr,
    input  logic          reload,
    input  logic          dec_blk,
    input  logic          dec_xfr,
    output logic          blk_zero,
    output logic          xfr_zero
);
    typedef struct packed {
        logic [CW-1:0] bc;
        logic [CW-1:0] blk;
        logic [CW-1:0] xfr;
    } cnt_regs_t;

    cnt_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.bc  = cfg_blk;
            c_d.blk = cfg_blk;
            c_d.xfr = cfg_xfr;
        end else begin
            if (reload)       c_d.blk = c_q.bc;
            else if (dec_blk) c_d.blk = c_q.blk - CW'(1);
            if (dec_xfr)      c_d.xfr = c_q.xfr - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign blk_zero = (c_q.blk == '0);
    assign xfr_zero = (c_q.xfr == '0);

    // R2: the word counter never wraps below zero
    a_r2_blk_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec_blk |-> !blk_zero);

    // R3: the request counter never wraps below zero
    a_r3_xfr_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec_xfr |-> !xfr_zero);

endmodule

// File: rtl/blkdma_addr.sv
module blkdma_addr
    import blkdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [1:0]    cfg_width,
    input  logic          step,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [1:0]    wcode;
    } addr_regs_t;

    addr_regs_t a_d, a_q;
    logic [AW-1:0] inc;

    always_comb begin
        a_d = a_q;
        inc = AW'(stride_of(a_q.wcode));
        if (load) begin
            a_d.src   = cfg_src;
            a_d.dst   = cfg_dst;
            a_d.wcode = cfg_width;
        end else if (step) begin
            a_d.src = a_q.src + inc;
            a_d.dst = a_q.dst + inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign src = a_q.src;
    assign dst = a_q.dst;

    // R6: both pointers move by the same power-of-two stride
    a_r6_stride_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ($countones(src - $past(src)) == 1)
                            && ((src - $past(src)) == (dst - $past(dst))));

endmodule

// File: rtl/blkdma_channel.sv
module blkdma_channel
    import blkdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_blk,
    input  logic [CW-1:0] cfg_xfr,
    input  logic [1:0]    cfg_width,
    input  logic          irq_clr,
    input  logic          dreq,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdy,
    output logic          busy,
    output logic          done_irq
);
    typedef struct packed {
        dma_state_e    st;
        logic          en;
        logic          done;
        logic [DW-1:0] data;
    } ch_regs_t;

    ch_regs_t s_d, s_q;

    logic          start, take, wr_done, dec_blk, dec_xfr, finish;
    logic          pend, blk_zero, xfr_zero;
    logic [AW-1:0] src, dst;

    always_comb begin
        s_d     = s_q;
        s_d.en  = cfg_en;
        start   = cfg_en & ~s_q.en & (s_q.st == ST_IDLE);
        take    = (s_q.st == ST_WAIT) & cfg_en & pend;
        wr_done = (s_q.st == ST_WR) & bus_rdy;
        dec_blk = wr_done & cfg_en & ~blk_zero;
        dec_xfr = wr_done & cfg_en & blk_zero & ~xfr_zero;
        finish  = wr_done & cfg_en & blk_zero & xfr_zero;

        case (s_q.st)
            ST_IDLE: if (start) s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (!cfg_en)   s_d.st = ST_IDLE;
                else if (pend) s_d.st = ST_RD;
            end
            ST_RD: begin
                if (bus_rdy) begin
                    s_d.data = bus_rdata;
                    s_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (bus_rdy) begin
                    if (!cfg_en || finish) s_d.st = ST_IDLE;
                    else if (dec_xfr)      s_d.st = ST_WAIT;
                    else                   s_d.st = ST_RD;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (finish)                s_d.done = 1'b1;
        else if (irq_clr || start) s_d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, en: 1'b0, done: 1'b0, data: '0};
        else        s_q <= s_d;
    end

    blkdma_req u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .dreq  (dreq),
        .arm   (s_q.st != ST_IDLE),
        .take  (take),
        .pend  (pend)
    );

    blkdma_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .cfg_blk  (cfg_blk),
        .cfg_xfr  (cfg_xfr),
        .reload   (take),
        .dec_blk  (dec_blk),
        .dec_xfr  (dec_xfr),
        .blk_zero (blk_zero),
        .xfr_zero (xfr_zero)
    );

    blkdma_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .cfg_src   (cfg_src),
        .cfg_dst   (cfg_dst),
        .cfg_width (cfg_width),
        .step      (wr_done),
        .src       (src),
        .dst       (dst)
    );

    assign bus_rd    = (s_q.st == ST_RD);
    assign bus_wr    = (s_q.st == ST_WR);
    assign bus_addr  = bus_wr ? dst : src;
    assign bus_wdata = s_q.data;
    assign busy      = (s_q.st != ST_IDLE);
    assign done_irq  = s_q.done;

    // R2: a write is only begun by a completed read
    a_r2_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_rd && bus_rdy));

    // R7: completion appears only as the last write retires and the channel idles
    a_r7_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> (!busy && $past(bus_wr && bus_rdy)));

    // R7: the flag holds until cleared or restarted
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !irq_clr && !(cfg_en && !s_q.en)) |=> done_irq);

    // R9: leaving busy without completion requires the enable to be low
    a_r9_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !done_irq) |-> $past(!cfg_en));

    // R8: an operation only begins on a fresh enable
    a_r8_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cfg_en && !s_q.en));

endmodule

// File: tb/blkdma_channel_test.sv
module blkdma_channel_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;
    localparam logic [31:0] PAT = 32'h5A5A_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [CW-1:0] cfg_blk = '0;
    logic [CW-1:0] cfg_xfr = '0;
    logic [1:0]    cfg_width = '0;
    logic          irq_clr = 1'b0;
    logic          dreq = 1'b0;
    logic          bus_rd, bus_wr, bus_rdy, busy, done_irq;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int tests = 0;
    int fails = 0;
    int lat = 0;
    int lcnt = 0;
    int wcnt = 0;
    int wbase = 0;
    logic [31:0] wlog_a [0:255];
    logic [31:0] wlog_d [0:255];

    always #4 clk = ~clk;

    blkdma_channel #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_blk(cfg_blk), .cfg_xfr(cfg_xfr),
        .cfg_width(cfg_width), .irq_clr(irq_clr), .dreq(dreq),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .busy(busy), .done_irq(done_irq)
    );

    // memory model: read data derived from the address, ready after lat cycles
    assign bus_rdata = bus_addr ^ PAT;

    initial bus_rdy = 1'b0;
    always @(posedge clk) begin
        if (bus_wr && bus_rdy && wcnt < 256) begin
            wlog_a[wcnt] <= bus_addr;
            wlog_d[wcnt] <= bus_wdata;
            wcnt <= wcnt + 1;
        end
        if ((bus_rd || bus_wr) && !bus_rdy) begin
            if (lcnt >= lat) begin
                bus_rdy <= 1'b1;
                lcnt <= 0;
            end else begin
                lcnt <= lcnt + 1;
            end
        end else begin
            bus_rdy <= 1'b0;
        end
    end

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(input logic [31:0] s, input logic [31:0] d,
                             input int bc, input int tc, input int w);
        @(negedge clk);
        cfg_src = s; cfg_dst = d;
        cfg_blk = CW'(bc); cfg_xfr = CW'(tc); cfg_width = 2'(w);
        wbase = wcnt;
    endtask

    task automatic start_ch();
        @(negedge clk); cfg_en = 1'b1; cyc(2);
    endtask

    task automatic stop_ch();
        @(negedge clk); cfg_en = 1'b0; cyc(2);
    endtask

    task automatic pulse_req();
        @(negedge clk); dreq = 1'b1; cyc(2); dreq = 1'b0; cyc(1);
    endtask

    task automatic wait_writes(input int n, input int tail);
        for (int i = 0; i < 4000 && (wcnt - wbase) < n; i++) @(negedge clk);
        cyc(tail);
    endtask

    task automatic check_log(input int n, input logic [31:0] s, input logic [31:0] d,
                             input int st, input string tag);
        for (int i = 0; i < n; i++) begin
            check(wlog_a[wbase+i] == d + 32'(i*st), {tag, " dst addr"},
                  wlog_a[wbase+i], d + 32'(i*st));
            check(wlog_d[wbase+i] == ((s + 32'(i*st)) ^ PAT), {tag, " data"},
                  wlog_d[wbase+i], (s + 32'(i*st)) ^ PAT);
        end
    endtask

    task automatic t_reset();
        cyc(1);
        check(!busy && !done_irq && !bus_rd && !bus_wr, "R10 reset outputs",
              {busy, done_irq, bus_rd, bus_wr}, 0);
    endtask

    task automatic t_basic();
        lat = 0;
        configure(32'h100, 32'h800, 3, 2, 2);
        start_ch();
        cyc(20);
        check((wcnt - wbase) == 0 && busy, "R4 no access before request", wcnt - wbase, 0);
        for (int k = 1; k <= 3; k++) begin
            pulse_req();
            wait_writes(4*k, 20);
            check((wcnt - wbase) == 4*k, "R2 words per request", wcnt - wbase, 4*k);
            if (k < 3) check(busy && !done_irq && !bus_rd && !bus_wr,
                             "R4 idle gap between blocks", {busy, done_irq}, 2'b10);
        end
        check(!busy, "R3 channel stops after last block", busy, 0);
        check(done_irq, "R7 completion flag", done_irq, 1);
        check_log(12, 32'h100, 32'h800, 4, "R6 stride 4");
        stop_ch();
    endtask

    task automatic t_level();
        lat = 1;
        configure(32'h40, 32'h400, 1, 1, 0);
        dreq = 1'b1;
        start_ch();
        cyc(30);
        check((wcnt - wbase) == 0, "R5 level before start ignored", wcnt - wbase, 0);
        dreq = 1'b0; cyc(2); dreq = 1'b1;
        cyc(60);
        check((wcnt - wbase) == 2, "R1 held level gives one block", wcnt - wbase, 2);
        check(busy, "R1 still waiting", busy, 1);
        dreq = 1'b0; cyc(2);
        pulse_req();
        wait_writes(4, 10);
        check((wcnt - wbase) == 4 && done_irq, "R3 total 2x2", wcnt - wbase, 4);
        check_log(4, 32'h40, 32'h400, 1, "R6 stride 1");
        stop_ch();
    endtask

    task automatic t_pending();
        lat = 2;
        configure(32'h200, 32'hA00, 2, 1, 1);
        start_ch();
        cfg_src = 32'hFFF0; cfg_dst = 32'h7770; cfg_blk = 8'd9; // R8 late changes
        pulse_req();
        wait_writes(1, 0);
        pulse_req();
        wait_writes(6, 40);
        check((wcnt - wbase) == 6, "R5 pending edge runs next block", wcnt - wbase, 6);
        check(done_irq && !busy, "R5 completes without extra edge", done_irq, 1);
        check_log(6, 32'h200, 32'hA00, 2, "R8 sampled config, R6 stride 2");
        stop_ch();
    endtask

    task automatic t_width3();
        lat = 0;
        configure(32'h300, 32'hC00, 1, 0, 3);
        start_ch();
        pulse_req();
        wait_writes(2, 10);
        check((wcnt - wbase) == 2 && done_irq, "R3 single block op", wcnt - wbase, 2);
        check_log(2, 32'h300, 32'hC00, 4, "R6 code 3 stride 4");
        // done remains while enable low
        stop_ch();
        cyc(25);
        check(done_irq, "R7 flag held with enable low", done_irq, 1);
    endtask

    task automatic t_done();
        lat = 0;
        configure(32'h10, 32'h20, 0, 0, 2);
        start_ch();
        check(!done_irq && busy, "R7 new start clears flag", done_irq, 0);
        pulse_req();
        wait_writes(1, 10);
        check(done_irq, "R7 flag after op", done_irq, 1);
        cyc(20);
        check(done_irq, "R7 flag held", done_irq, 1);
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check(!done_irq, "R7 flag cleared by irq_clr", done_irq, 0);
        stop_ch();
    endtask

    task automatic t_abort();
        lat = 1;
        configure(32'h500, 32'hE00, 7, 3, 2);
        start_ch();
        pulse_req();
        wait_writes(2, 0);
        cfg_en = 1'b0;
        cyc(40);
        check((wcnt - wbase) == 3, "R9 abort after word in flight", wcnt - wbase, 3);
        check(!busy && !done_irq, "R9 idle with flag clear", {busy, done_irq}, 0);
        pulse_req();
        cyc(30);
        check((wcnt - wbase) == 3, "R9 no access after abort", wcnt - wbase, 3);
        check_log(3, 32'h500, 32'hE00, 4, "R9 aborted words");
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_level();
        t_pending();
        t_width3();
        t_done();
        t_abort();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule